// File: doc/BRIEF.md
# Compare Timer with Absolute and Relative Views

This block is a 64-bit system-counter timer with two timer instances, one physical and one virtual, that share a single free-running counter. Software programs a timer in one of two ways. It can write an absolute compare value as two 32-bit halves. It can also write a signed 32-bit down-count, which is added to the timer's current view of the counter. The physical instance sees the raw counter. The virtual instance sees the counter minus a programmable 64-bit offset.

Each timer decides every cycle whether it has fired. The test takes the difference between its counter view and its compare value, modulo 2^64, and reads that difference as a signed number. A timer fires when the difference is non-negative. A compare value that is already in the past therefore fires at once and does not wait for a wrap. Each timer has an enable bit and an interrupt mask. It drives a level interrupt while it is enabled, has fired and is unmasked.

Access is through a plain 32-bit register bus. A write strobe is latched on the rising clock edge, and read data is combinational from the address. Address bit 6 selects the timer page: 0 for physical, 1 for virtual. The counter starts from a parameterised value and implements `CNT_BITS` bits, so it can be checked across its wrap point.

Top module: `cmp_timer`

## Requirements
- R1: The counter loads `CNT_INIT` in reset and then increases by one on every clock edge. It is `CNT_BITS` bits wide, wraps to zero, and bits at or above `CNT_BITS` read as zero. Its low and high halves read at offsets 0x18 and 0x1C.
- R2: Writes to offset 0x08 and 0x0C replace the low and high 32 bits of the page's compare value, and the same offsets read the value back.
- R3: A write of W to offset 0x10 sets compare to (view count at that edge + W sign-extended to 64 bits), modulo 2^64.
- R4: A read of offset 0x10 returns the low 32 bits of (compare − current view count).
- R5: The status bit is 1 exactly when the timer is enabled and (view count − compare) modulo 2^64 has bit 63 clear. A compare value at or below the view count shows status 1 in the first cycle after the write edge.
- R6: The physical view count equals the counter. The virtual view count equals (counter − offset) modulo 2^64, where the offset is written at 0x20 (low) and 0x24 (high) from either page. The offset has no effect on the physical timer.
- R7: While enable is 0, the status bit reads 0 and the timer's interrupt is 0.
- R8: The control word at offset 0x00 holds enable in bit 0, mask in bit 1 and the read-only status in bit 2. Bits written to position 2 are ignored. Both control bits reset to 0.
- R9: Each interrupt output equals status AND NOT mask for its timer. Setting the mask does not change the status bit.
- R10: When a compare write (either half, or the relative view) moves the compare value past the view count, a pending status clears in the first cycle after that write.
- R11: Address bit 6 selects the timer: 0 selects physical and 1 selects virtual. A write to one page leaves the other timer's compare value and control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, latched on the rising edge |
| bus_addr | input | 7 | Byte address; bit 6 selects the page, bits 5:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_phys | output | 1 | Level interrupt of the physical timer |
| irq_virt | output | 1 | Level interrupt of the virtual timer |

## Verification
Every register write lands on the rising edge that samples the strobe. The counter advances on every edge. Status, interrupts and all read data are combinational from registers, so the result of a write can be seen in the cycle after its edge. The bench drives on one edge and samples one nanosecond after a falling edge. It keeps its own count of counter ticks from reset and computes each expected compare value, status and relative read from that count at the sampling instant. Expectations therefore stay exact however many cycles a task spends between a write and a check.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int          CNT_BITS = 64,
  parameter logic [63:0] CNT_INIT = 64'd0,
  parameter logic [63:0] CMP_INIT = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_phys,
  output logic        irq_virt
);
  localparam logic [63:0] CNT_MASK = (CNT_BITS >= 64) ? '1 : ((64'd1 << CNT_BITS) - 64'd1);
  localparam logic [5:0] A_CTRL   = 6'h00;
  localparam logic [5:0] A_CMP_LO = 6'h08;
  localparam logic [5:0] A_CMP_HI = 6'h0C;
  localparam logic [5:0] A_REL    = 6'h10;
  localparam logic [5:0] A_CNT_LO = 6'h18;
  localparam logic [5:0] A_CNT_HI = 6'h1C;
  localparam logic [5:0] A_OFF_LO = 6'h20;
  localparam logic [5:0] A_OFF_HI = 6'h24;

  logic [63:0]       cnt_q, off_q;
  logic [1:0]        en_q, mask_q, istat;
  logic [1:0][63:0]  cmp_q, view_cnt;
  logic [5:0]        reg_a;
  logic              page;

  assign reg_a = bus_addr[5:0];
  assign page  = bus_addr[6];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_INIT & CNT_MASK;
    else        cnt_q <= (cnt_q + 64'd1) & CNT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= '0;
    else if (bus_wr && reg_a == A_OFF_LO) off_q[31:0]  <= bus_wdata;
    else if (bus_wr && reg_a == A_OFF_HI) off_q[63:32] <= bus_wdata;
  end

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    logic        en_r, mask_r, hit;
    logic [63:0] cmp_r, vc, diff;

    assign hit  = bus_wr && (page == 1'(i));
    assign vc   = (i == 0) ? cnt_q : cnt_q - off_q;
    assign diff = vc - cmp_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        mask_r <= 1'b0;
        cmp_r  <= CMP_INIT;
      end else if (hit) begin
        case (reg_a)
          A_CTRL:   begin en_r <= bus_wdata[0]; mask_r <= bus_wdata[1]; end
          A_CMP_LO: cmp_r[31:0]  <= bus_wdata;
          A_CMP_HI: cmp_r[63:32] <= bus_wdata;
          A_REL:    cmp_r <= vc + {{32{bus_wdata[31]}}, bus_wdata};
          default:  ;
        endcase
      end
    end

    assign en_q[i]     = en_r;
    assign mask_q[i]   = mask_r;
    assign istat[i]    = en_r & ~diff[63];
    assign cmp_q[i]    = cmp_r;
    assign view_cnt[i] = vc;
  end

  assign irq_phys = istat[0] & ~mask_q[0];
  assign irq_virt = istat[1] & ~mask_q[1];

  always_comb begin
    bus_rdata = '0;
    case (reg_a)
      A_CTRL:   bus_rdata = {29'd0, istat[page], mask_q[page], en_q[page]};
      A_CMP_LO: bus_rdata = cmp_q[page][31:0];
      A_CMP_HI: bus_rdata = cmp_q[page][63:32];
      A_REL:    bus_rdata = cmp_q[page][31:0] - view_cnt[page][31:0];
      A_CNT_LO: bus_rdata = view_cnt[page][31:0];
      A_CNT_HI: bus_rdata = view_cnt[page][63:32];
      A_OFF_LO: bus_rdata = off_q[31:0];
      A_OFF_HI: bus_rdata = off_q[63:32];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

module cmp_timer_sva #(
  parameter int CNT_BITS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [6:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq_phys,
  input logic             irq_virt,
  input logic [63:0]      cnt_q,
  input logic [63:0]      off_q,
  input logic [1:0]       en_q,
  input logic [1:0]       mask_q,
  input logic [1:0]       istat,
  input logic [1:0][63:0] cmp_q
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >> CNT_BITS) == 64'd0);

  a_r2_cmp_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h08) |=> cmp_q[0][31:0] == $past(bus_wdata));

  a_r3_rel_write_phys: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h10) |=>
      cmp_q[0] == $past(cnt_q) + {{32{$past(bus_wdata[31])}}, $past(bus_wdata)});

  a_r6_rel_write_virt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 7'h50) |=>
      cmp_q[1] == $past(cnt_q) - $past(off_q) + {{32{$past(bus_wdata[31])}}, $past(bus_wdata)});

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> (!irq_phys && !istat[0]));

  a_r9_irq_phys_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_phys |-> (en_q[0] && !mask_q[0] && istat[0]));

  a_r9_irq_virt_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_virt |-> (en_q[1] && !mask_q[1] && istat[1]));

  a_r11_page_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[6]) |=> (cmp_q[0] == $past(cmp_q[0]) && en_q[0] == $past(en_q[0])));
endmodule

bind cmp_timer cmp_timer_sva #(.CNT_BITS(CNT_BITS)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_phys(irq_phys), .irq_virt(irq_virt), .cnt_q(cnt_q), .off_q(off_q),
  .en_q(en_q), .mask_q(mask_q), .istat(istat), .cmp_q(cmp_q)
);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
  localparam int          TB_BITS = 56;
  localparam logic [63:0] TB_INIT = (64'd1 << TB_BITS) - 64'd400;
  localparam logic [63:0] TB_MASK = (64'd1 << TB_BITS) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_phys, irq_virt;

  cmp_timer #(.CNT_BITS(TB_BITS), .CNT_INIT(TB_INIT), .CMP_INIT(64'd0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_phys(irq_phys), .irq_virt(irq_virt)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] ecnt;
  logic [63:0] eoff = '0;
  logic [63:0] last_c;
  logic [63:0] ecmp [2];
  logic        een [2];
  logic        emsk [2];

  always @(posedge clk) begin
    if (!rst_n) ecnt <= TB_INIT & TB_MASK;
    else        ecnt <= (ecnt + 64'd1) & TB_MASK;
  end

  function automatic logic [63:0] view(input int t, input logic [63:0] c);
    return (t == 0) ? c : c - eoff;
  endfunction

  function automatic logic exp_st(input int t);
    logic [63:0] d;
    d = view(t, ecnt) - ecmp[t];
    return een[t] && !d[63];
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    int t;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    last_c = ecnt;
    t = int'(a[6]);
    case (a[5:0])
      6'h00: begin een[t] = d[0]; emsk[t] = d[1]; end
      6'h08: ecmp[t][31:0]  = d;
      6'h0C: ecmp[t][63:32] = d;
      6'h10: ecmp[t] = view(t, last_c) + {{32{d[31]}}, d};
      6'h20: eoff[31:0]  = d;
      6'h24: eoff[63:32] = d;
      default: ;
    endcase
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_ctrl(input int t, input string tag);
    logic [31:0] d;
    logic        irq_exp;
    rd({t[0], 6'h00}, d);
    chk({tag, " ctrl"}, {61'd0, d[2:0]}, {61'd0, exp_st(t), emsk[t], een[t]});
    irq_exp = exp_st(t) & ~emsk[t];
    chk({tag, " irq"}, {63'd0, (t == 0) ? irq_phys : irq_virt}, {63'd0, irq_exp});
  endtask

  task automatic chk_rel(input int t, input string tag);
    logic [31:0] d;
    logic [63:0] e;
    rd({t[0], 6'h10}, d);
    e = ecmp[t] - view(t, ecnt);
    chk(tag, {32'd0, d}, {32'd0, e[31:0]});
  endtask

  task automatic t_reset();
    logic [31:0] lo, hi;
    for (int t = 0; t < 2; t++) begin een[t] = 1'b0; emsk[t] = 1'b0; ecmp[t] = 64'd0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_ctrl(0, "R8 reset phys");
    chk_ctrl(1, "R8 reset virt");
    rd(7'h18, lo); chk("R1 reset count lo", {32'd0, lo}, {32'd0, ecnt[31:0]});
    rd(7'h1C, hi); chk("R1 reset count hi", {32'd0, hi}, {32'd0, ecnt[63:32]});
  endtask

  task automatic t_counter_wrap();
    logic [31:0] lo, hi;
    rd(7'h1C, hi);
    chk("R1 pre-wrap hi", {32'd0, hi}, 64'h0000_0000_00FF_FFFF);
    repeat (450) @(posedge clk);
    rd(7'h18, lo); chk("R1 post-wrap lo", {32'd0, lo}, {32'd0, ecnt[31:0]});
    rd(7'h1C, hi); chk("R1 post-wrap hi zero", {32'd0, hi}, 64'd0);
  endtask

  task automatic t_cmp_halves();
    logic [31:0] d;
    wr(7'h00, 32'h1);
    chk_ctrl(0, "R5 past compare fires");
    wr(7'h0C, 32'h1);
    chk_ctrl(0, "R10 high half future clears");
    wr(7'h08, 32'hABCD_0123);
    rd(7'h08, d); chk("R2 cmp lo readback", {32'd0, d}, 64'h0000_0000_ABCD_0123);
    rd(7'h0C, d); chk("R2 cmp hi readback", {32'd0, d}, 64'd1);
    wr(7'h0C, 32'h0);
    chk_ctrl(0, "R10 still future");
    wr(7'h08, 32'h5);
    chk_ctrl(0, "R5 low half past fires");
  endtask

  task automatic t_rel();
    logic [31:0] d;
    wr(7'h10, 32'd40);
    rd(7'h08, d); chk("R3 rel sets cmp lo", {32'd0, d}, {32'd0, ecmp[0][31:0]});
    chk("R3 rel model", ecmp[0], last_c + 64'd40);
    chk_ctrl(0, "R10 rel future clears");
    chk_rel(0, "R4 rel countdown");
    repeat (50) @(posedge clk);
    chk_ctrl(0, "R5 fires after countdown");
    chk_rel(0, "R4 rel negative after expiry");
  endtask

  task automatic t_rel_neg();
    logic [31:0] d;
    wr(7'h0C, 32'h7);
    chk_ctrl(0, "R10 set future");
    wr(7'h10, 32'hFFFF_FFF0);
    chk_ctrl(0, "R3 negative rel fires at once");
    wr(7'h10, 32'h8000_0000);
    rd(7'h0C, d); chk("R3 sign extension wraps", {32'd0, d}, 64'h0000_0000_FFFF_FFFF);
    chk_ctrl(0, "R5 wrapped compare in past");
  endtask

  task automatic t_mask();
    wr(7'h00, 32'h7);
    chk_ctrl(0, "R9 mask keeps status");
    wr(7'h10, 32'd1000);
    wr(7'h00, 32'h5);
    chk_ctrl(0, "R8 status write ignored");
    wr(7'h10, 32'hFFFF_FFFF);
    chk_ctrl(0, "R9 unmasked irq");
  endtask

  task automatic t_disable();
    wr(7'h00, 32'h0);
    chk_ctrl(0, "R7 disabled past compare");
  endtask

  task automatic t_virtual();
    logic [31:0] lo, hi;
    logic [63:0] target;
    wr(7'h20, 32'h0000_1000);
    wr(7'h64, 32'h0);
    rd(7'h58, lo); chk("R6 virt count lo", {32'd0, lo}, {32'd0, view(1, ecnt) & 64'hFFFF_FFFF});
    rd(7'h5C, hi); chk("R6 virt count hi", {32'd0, hi}, {32'd0, view(1, ecnt) >> 32});
    rd(7'h18, lo); chk("R6 phys ignores offset", {32'd0, lo}, {32'd0, ecnt[31:0]});
    target = ecnt + 64'd100;
    wr(7'h60, target[31:0]);
    wr(7'h24, target[63:32]);
    wr(7'h48, 32'hFFFF_FFF6);
    wr(7'h4C, 32'hFFFF_FFFF);
    wr(7'h40, 32'h1);
    chk_ctrl(1, "R5 near-wrap not yet");
    chk_ctrl(0, "R11 phys untouched");
    chk_rel(1, "R4 virt rel");
    repeat (150) @(posedge clk);
    chk_ctrl(1, "R5 fires across 2^64 wrap");
    wr(7'h50, 32'd20);
    chk_ctrl(1, "R6 virt rel future");
    chk_rel(1, "R6 virt rel readback");
  endtask

  initial begin
    t_reset();
    t_counter_wrap();
    t_cmp_halves();
    t_rel();
    t_rel_neg();
    t_mask();
    t_disable();
    t_virtual();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule